// File: doc/BRIEF.md
# Dual-Plane Page Write Controller

This block manages writes into a byte-wide nonvolatile array that is split into two equal planes. The top address bit picks the plane. The host stores between one and `PAGE_BYTES` bytes of a single page into a page buffer. Each accepted byte restarts a load-window timer. When no further byte arrives before the window runs out, a programming phase of fixed length begins. During that phase the buffered bytes are committed to the target plane, and all other bytes of the page keep their contents.

The other plane can still be read normally while programming is under way. A read of the plane being programmed returns a status byte instead of array data, and bit 6 of that byte alternates on each such read, so software can poll for completion. A write-inhibit input cancels a pending page while the window is still open. An optional interrupt is raised when programming completes and stays set until software clears it. The load window and the programming time are parameters counted in clock cycles. The array is modelled as plain storage.

Top module: `dual_plane_page_writer`

## Requirements
- R1: After reset, `busy_o`, `irq_o` and `rd_data_o` are all zero.
- R2: Programming (`busy_o` high) starts exactly `WINDOW_CYC` clock edges after the edge that accepted the most recent page byte. Every accepted byte restarts this count.
- R3: Programming lasts `PROG_CYC` edges, and `busy_o` then drops. Bytes loaded into the page are readable afterwards, and the page bytes that were not loaded keep their earlier values.
- R4: A page byte goes to the offset given by the low `log2(PAGE_BYTES)` address bits. If an offset is loaded twice before programming, the later byte wins.
- R5: While a page is loading, a write whose address above the page offset differs from the first byte's is ignored. It is not stored and it does not restart the window.
- R6: While one plane is programming, a read of the other plane (the other value of the top address bit) returns array data.
- R7: While a plane is programming, a read of that plane returns a status byte. Every bit of the status byte is 0 except bit 6. Bit 6 is 0 on the first such read of a programming phase and inverts on each later one.
- R8: If `wc_i` is high on any edge while a page is loading, the page is dropped, no programming follows and the array is unchanged. A write presented while `wc_i` is high is ignored.
- R9: Writes presented while programming is under way are ignored.
- R10: If `irq_en_i` is high on the edge that ends programming, `irq_o` goes high and stays high until `irq_clr_i` is sampled high. If `irq_en_i` is low on that edge, `irq_o` stays low.
- R11: `rd_data_o` shows the result of a read one edge after `rd_en_i` is sampled. It holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| wr_addr_i | input | ADDR_W | Write byte address; the top bit selects the plane |
| wr_data_i | input | DATA_W | Write data |
| wc_i | input | 1 | Write inhibit; high cancels the loading page |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Registered read data or status byte |
| irq_en_i | input | 1 | Enables the completion interrupt |
| irq_clr_i | input | 1 | Clears the interrupt |
| irq_o | output | 1 | Completion interrupt, sticky |
| busy_o | output | 1 | Programming phase in progress |

## Verification
The main function is tried with four write patterns:
- **Multi-byte page with a repeated offset.** This separates the window measured from the last byte from a window measured from the first byte, and it shows which duplicate wins.
- **Page with a stray write to another page partway through.** This shows whether a foreign address leaks into the buffer or extends the window.
- **Writes cut short by the inhibit input.** These show that cancellation leaves the array unchanged.
- **A one-byte rewrite of a page programmed earlier.** This shows that untouched offsets survive.

During a programming phase, reads alternate between the busy plane and the idle plane. This separates array data from status bytes and shows that the toggle advances only on busy-plane reads.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwc_state_e;

  localparam int unsigned STATUS_BIT = 6;
endpackage

// File: rtl/pwc_seq.sv
module pwc_seq
  import pwc_pkg::*;
#(
  parameter int unsigned WINDOW_CYC = 12,
  parameter int unsigned PROG_CYC   = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_take_i,
  input  logic       wc_i,
  output pwc_state_e state_o,
  output logic       prog_start_o,
  output logic       prog_done_o,
  output logic       cancel_o
);
  localparam int unsigned WCW = $clog2(WINDOW_CYC + 1);
  localparam int unsigned PCW = $clog2(PROG_CYC + 1);

  pwc_state_e     state_q, state_d;
  logic [WCW-1:0] win_q, win_d;
  logic [PCW-1:0] prog_q, prog_d;

  assign cancel_o     = (state_q == ST_LOAD) && wc_i;
  assign prog_start_o = (state_q == ST_LOAD) && !wc_i && !wr_take_i && (win_q == WCW'(1));
  assign prog_done_o  = (state_q == ST_PROG) && (prog_q == PCW'(1));

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    prog_d  = prog_q;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_take_i) begin
          state_d = ST_LOAD;
          win_d   = WCW'(WINDOW_CYC);
        end
      end
      ST_LOAD: begin
        if (wc_i) begin
          state_d = ST_IDLE;
        end else if (wr_take_i) begin
          win_d = WCW'(WINDOW_CYC);
        end else if (win_q == WCW'(1)) begin
          state_d = ST_PROG;
          prog_d  = PCW'(PROG_CYC);
        end else begin
          win_d = win_q - WCW'(1);
        end
      end
      ST_PROG: begin
        if (prog_q == PCW'(1)) state_d = ST_IDLE;
        else                   prog_d  = prog_q - PCW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      prog_q  <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      prog_q  <= prog_d;
    end
  end

  assign state_o = state_q;

  // window count never runs to zero while loading
  assert_window_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |-> (win_q != '0));
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_i,
  input  logic              wr_take_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              drain_i,
  input  logic              clear_i,
  output logic              page_hit_o,
  output logic              plane_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [TAG_W-1:0]      tag_q;
  logic [OFF_W:0]        idx_q;
  logic [OFF_W-1:0]      wr_off, rd_off;
  logic                  idx_live;

  assign wr_off     = wr_addr_i[OFF_W-1:0];
  assign rd_off     = idx_q[OFF_W-1:0];
  assign idx_live   = idx_q < (OFF_W+1)'(PAGE_BYTES);
  assign page_hit_o = wr_addr_i[ADDR_W-1:OFF_W] == tag_q;
  assign plane_o    = tag_q[TAG_W-1];
  assign mem_we_o   = drain_i && idx_live && vld_q[rd_off];
  assign mem_addr_o = {tag_q, rd_off};
  assign mem_data_o = data_q[rd_off];

  always_ff @(posedge clk_i) begin
    if (wr_take_i) data_q[wr_off] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
      idx_q <= '0;
    end else begin
      if (wr_take_i) begin
        vld_q[wr_off] <= 1'b1;
        if (first_i) tag_q <= wr_addr_i[ADDR_W-1:OFF_W];
      end
      if (drain_i && idx_live) idx_q <= idx_q + (OFF_W+1)'(1);
    end
  end

  // once the buffer is open, every stored byte belongs to the captured page
  assert_same_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_take_i && !first_i) |-> page_hit_o);
endmodule

// File: rtl/pwc_plane_mem.sv
module pwc_plane_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned LOC_W = ADDR_W - 1;
  localparam int unsigned DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] rd_pl [2];

  for (genvar g = 0; g < 2; g++) begin : g_plane
    logic [DATA_W-1:0] cells [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i[ADDR_W-1] == 1'(g))) cells[waddr_i[LOC_W-1:0]] <= wdata_i;
    end
    assign rd_pl[g] = cells[raddr_i[LOC_W-1:0]];
  end

  assign rdata_o = rd_pl[raddr_i[ADDR_W-1]];
endmodule

// File: rtl/dual_plane_page_writer.sv
module dual_plane_page_writer
  import pwc_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WINDOW_CYC = 12,
  parameter int unsigned PROG_CYC   = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wc_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              busy_o
);
  pwc_state_e        state;
  logic              prog_start, prog_done, cancel;
  logic              page_hit, busy_plane, wr_take;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, status;
  logic              rd_busy_hit;
  logic              tog_q, irq_q;
  logic [DATA_W-1:0] rd_q;

  assign busy_o  = state == ST_PROG;
  assign wr_take = wr_en_i && !wc_i &&
                   ((state == ST_IDLE) || ((state == ST_LOAD) && page_hit));

  pwc_seq #(.WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk_i, .rst_ni,
    .wr_take_i   (wr_take),
    .wc_i,
    .state_o     (state),
    .prog_start_o(prog_start),
    .prog_done_o (prog_done),
    .cancel_o    (cancel)
  );

  pwc_page_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .first_i   (state == ST_IDLE),
    .wr_take_i (wr_take),
    .wr_addr_i,
    .wr_data_i,
    .drain_i   (busy_o),
    .clear_i   (cancel || prog_done),
    .page_hit_o(page_hit),
    .plane_o   (busy_plane),
    .mem_we_o  (mem_we),
    .mem_addr_o(mem_addr),
    .mem_data_o(mem_wdata)
  );

  pwc_plane_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i,
    .we_i   (mem_we),
    .waddr_i(mem_addr),
    .wdata_i(mem_wdata),
    .raddr_i(rd_addr_i),
    .rdata_o(mem_rdata)
  );

  assign rd_busy_hit = rd_en_i && busy_o && (rd_addr_i[ADDR_W-1] == busy_plane);

  always_comb begin
    status             = '0;
    status[STATUS_BIT] = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      tog_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (rd_busy_hit)  rd_q <= status;
      else if (rd_en_i) rd_q <= mem_rdata;
      if (prog_start)       tog_q <= 1'b0;
      else if (rd_busy_hit) tog_q <= ~tog_q;
      if (prog_done && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)        irq_q <= 1'b0;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  assert_prog_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(state == ST_LOAD));
  assert_store_in_prog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy_o);
  assert_cancel_no_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel |=> !busy_o);
  assert_status_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_hit |=> ((rd_data_o & ~(DATA_W'(1) << STATUS_BIT)) == '0));
  assert_status_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_hit |=> (rd_data_o[STATUS_BIT] != tog_q));
  assert_irq_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_done && irq_en_i) |=> irq_o);
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/dual_plane_page_writer_tb_top.sv
module dual_plane_page_writer_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 11;
  localparam int unsigned PB = 32;
  localparam int unsigned W  = 12;
  localparam int unsigned P  = 48;
  localparam int unsigned PL1 = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wc = 1'b0, rd_en = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          irq, busy;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  dual_plane_page_writer #(.DATA_W(DW), .ADDR_W(AW), .PAGE_BYTES(PB),
                           .WINDOW_CYC(W), .PROG_CYC(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wc_i(wc),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_o(irq), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    exp_q.push_back(DW'(exp));
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops one expected item per sampled read
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("monitor-queue", 1, 0);
        end else begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, int'(rd_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;

    // plane 1 page 0, repeated offset, interrupt enabled
    irq_en = 1'b1;
    wr(PL1 + 0, 'h10);
    wr(PL1 + 1, 'h11);
    wr(PL1 + 2, 'h12);
    wr(PL1 + 31, 'hA5);
    wr(PL1 + 2, 'h77);
    for (int k = 1; k <= int'(W + P); k++) begin
      @(negedge clk);
      if (k == int'(W) - 1)     chk("R2 busy before window end", int'(busy), 0);
      if (k == int'(W))         chk("R2 busy at window end", int'(busy), 1);
      if (k == int'(W + P) - 1) begin
        chk("R3 busy last prog cycle", int'(busy), 1);
        chk("R10 irq before done", int'(irq), 0);
      end
      if (k == int'(W + P)) begin
        chk("R3 busy after prog", int'(busy), 0);
        chk("R10 irq after done", int'(irq), 1);
      end
    end
    repeat (3) @(negedge clk);
    chk("R10 irq sticky", int'(irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R10 irq cleared", int'(irq), 0);
    rd(PL1 + 0, 'h10, "R3 byte0");
    rd(PL1 + 1, 'h11, "R3 byte1");
    rd(PL1 + 2, 'h77, "R4 duplicate offset");
    rd(PL1 + 31, 'hA5, "R4 last offset");

    // plane 0 page 0 with stray write to another page, interrupt disabled
    irq_en = 1'b0;
    wr(5, 'h55);
    repeat (4) @(negedge clk);
    wr(PL1 + 0, 'h99);
    repeat (5) @(negedge clk);
    chk("R5 stray write no restart (idle)", int'(busy), 0);
    @(negedge clk);
    chk("R5 stray write no restart (prog)", int'(busy), 1);
    rd(PL1 + 0, 'h10, "R6 idle plane read");
    rd(7, 'h00, "R7 status first");
    rd(9, 'h40, "R7 status second");
    rd(PL1 + 1, 'h11, "R6 idle plane read 2");
    rd(0, 'h00, "R7 status third");
    wr(PL1 + 31, 'h00);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    chk("R3 prog ended", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R10 irq stays low when disabled", int'(irq), 0);
    chk("R9 no restart after ignored write", int'(busy), 0);
    rd(5, 'h55, "R3 plane0 byte");
    rd(PL1 + 0, 'h10, "R5 stray byte not stored");
    rd(PL1 + 31, 'hA5, "R9 write during prog ignored");

    // cancel by inhibit while loading
    wr(PL1 + 1, 'hEE);
    @(negedge clk);
    wc = 1'b1;
    @(negedge clk);
    wc = 1'b0;
    for (int k = 0; k < int'(W + 4); k++) begin
      @(negedge clk);
      if (busy) chk("R8 no prog after cancel", 1, 0);
    end
    chk("R8 idle after cancel", int'(busy), 0);
    rd(PL1 + 1, 'h11, "R8 cancelled byte");
    wc = 1'b1;
    wr(PL1 + 2, 'hEE);
    wc = 1'b0;
    repeat (W + 3) @(negedge clk);
    chk("R8 inhibited write no prog", int'(busy), 0);
    rd(PL1 + 2, 'h77, "R8 inhibited byte");

    // single-byte rewrite keeps untouched offsets
    wr(PL1 + 0, 'h3C);
    for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    rd(PL1 + 0, 'h3C, "R3 rewritten byte");
    rd(PL1 + 1, 'h11, "R3 untouched byte kept");
    @(negedge clk);
    chk("R11 rd_data holds", int'(rd_data), 'h11);
    repeat (2) @(negedge clk);
    chk("R11 rd_data still holds", int'(rd_data), 'h11);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule